// File: doc/BRIEF.md
# SDRAM Refresh Interval Timer

This block paces refresh for an SDRAM controller. A free-running prescaler divides the input clock, and a clock-select code picks one of its taps as the count tick. An 8-bit interval counter advances on each tick. When a tick arrives while the counter equals the interval constant, three things happen: the counter returns to zero, a sticky match flag sets, and a one-cycle refresh request goes to the command sequencer.

Software reaches three registers over a simple 32-bit register port. Every write must carry a 16-bit key in the upper half of the data. The match flag clears only through a handshake: software reads the flag as 1, then writes 0 to it. There are two resets. Power-on reset clears everything, including the prescaler phase. Manual reset keeps the configuration and clears only the counting state.

Top module: `sdram_refresh_timer`

## Requirements
- R1: A write changes a register only when wdata[31:16] equals 0xA55A. A write without that key leaves the addressed register unchanged.
- R2: Power-on reset (por_n low) clears the control/status word to 0, the counter to 0 and the prescaler to 0, and sets the constant to all ones. Manual reset leaves the control/status word unchanged.
- R3: When a count tick occurs while the counter equals the constant, the counter reloads to 0, the flag (status bit 7) sets, and refresh_req goes high for exactly one cycle. Consecutive requests are therefore (constant+1) × divisor cycles apart.
- R4: Address 0 is control/status, address 1 is the counter and address 2 is the constant. Address 3 reads 0, and status bits 31:8 and 2:0 always read 0.
- R5: The flag clears only when a keyed status write with bit 7 = 0 follows a status read that returned the flag as 1. A zero-write with no such read leaves the flag set.
- R6: Writing 1 to bit 7 never sets the flag. A match in the same cycle as a valid clear leaves the flag set.
- R7: Status bits 5:3 select the tick. Code 0 stops the counter. Codes 1 to 7 divide the clock by 4, 16, 64, 256, 1024, 2048 and 4096.
- R8: irq equals the flag ANDed with the enable in status bit 6.
- R9: Manual reset (mrst_n low) clears the counter and the read-before-clear state and suppresses refresh_req. The constant keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| mrst_n | input | 1 | Manual reset, active low |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data with key in bits 31:16 |
| rdata | output | 32 | Read data for addr |
| refresh_req | output | 1 | One-cycle refresh request |
| irq | output | 1 | Flag gated by enable |

## Verification
The bench builds the block with its default 8-bit counter and key 0xA55A. It runs every clock-select code with the constant set to 1, so even the 4096 divisor produces several requests within a short run. It measures the spacing between the second and third requests after each code change, which keeps the measurement clear of prescaler phase error. A small constant also lets the flag handshake and the manual-reset checks complete within a few dozen cycles.

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int          CNT_W = 8,
  parameter logic [15:0] KEY   = 16'hA55A
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        mrst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        refresh_req,
  output logic        irq
);
  localparam int PRE_W = 12;

  logic [PRE_W-1:0] pre_q, mask;
  logic [2:0]       cks_q;
  logic             ie_q, flag_q, arm_q;
  logic [CNT_W-1:0] cnt_q, cor_q;
  logic             keyed, wr_csr, wr_cnt, wr_cor, rd_csr, tick, match, clr;

  assign keyed  = sel && wr && (wdata[31:16] == KEY);
  assign wr_csr = keyed && (addr == 2'd0);
  assign wr_cnt = keyed && (addr == 2'd1);
  assign wr_cor = keyed && (addr == 2'd2);
  assign rd_csr = sel && !wr && (addr == 2'd0);

  always_comb begin
    case (cks_q)
      3'd1:    mask = 12'h003;
      3'd2:    mask = 12'h00F;
      3'd3:    mask = 12'h03F;
      3'd4:    mask = 12'h0FF;
      3'd5:    mask = 12'h3FF;
      3'd6:    mask = 12'h7FF;
      3'd7:    mask = 12'hFFF;
      default: mask = 12'h000;
    endcase
  end

  assign tick  = (cks_q != 3'd0) && ((pre_q & mask) == mask);
  assign match = tick && (cnt_q == cor_q);
  assign clr   = wr_csr && arm_q && !wdata[7];

  always_ff @(posedge clk) begin
    if (!por_n) pre_q <= '0;
    else        pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cks_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (!mrst_n) begin
      arm_q  <= 1'b0;
    end else begin
      if (wr_csr) begin
        cks_q <= wdata[5:3];
        ie_q  <= wdata[6];
      end
      if (match)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (wr_csr)                arm_q <= 1'b0;
      else if (rd_csr && flag_q) arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      cnt_q       <= '0;
      cor_q       <= '1;
      refresh_req <= 1'b0;
    end else if (!mrst_n) begin
      cnt_q       <= '0;
      refresh_req <= 1'b0;
    end else begin
      refresh_req <= match;
      if (wr_cnt)     cnt_q <= wdata[CNT_W-1:0];
      else if (match) cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
      if (wr_cor)     cor_q <= wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {24'd0, flag_q, ie_q, cks_q, 3'd0};
      2'd1:    rdata = 32'(cnt_q);
      2'd2:    rdata = 32'(cor_q);
      default: rdata = '0;
    endcase
  end

  assign irq = flag_q & ie_q;
endmodule

// File: rtl/sdram_refresh_timer_chk.sv
module sdram_refresh_timer_chk #(
  parameter int          CNT_W = 8,
  parameter logic [15:0] KEY   = 16'hA55A
) (
  input logic             clk,
  input logic             por_n,
  input logic             mrst_n,
  input logic             sel,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             refresh_req,
  input logic [2:0]       cks_q,
  input logic             ie_q,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q
);
  a_r1_keyless_csr: assert property (@(posedge clk) disable iff (!por_n)
    (sel && wr && addr == 2'd0 && wdata[31:16] != KEY) |=> ($stable(cks_q) && $stable(ie_q)));

  a_r3_req_single: assert property (@(posedge clk) disable iff (!por_n)
    refresh_req |=> !refresh_req);

  a_r3_req_flag: assert property (@(posedge clk) disable iff (!por_n)
    refresh_req |-> flag_q);

  a_r6_flag_rise: assert property (@(posedge clk) disable iff (!por_n)
    $rose(flag_q) |-> refresh_req);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!por_n)
    (addr == 2'd0) |-> (rdata[31:8] == 24'd0 && rdata[2:0] == 3'd0));

  a_r7_stopped: assert property (@(posedge clk) disable iff (!por_n)
    (cks_q == 3'd0 && mrst_n && !(sel && wr && addr == 2'd1)) |=> $stable(cnt_q));
endmodule

bind sdram_refresh_timer sdram_refresh_timer_chk #(.CNT_W(CNT_W), .KEY(KEY)) chk_i (
  .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .sel(sel), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .refresh_req(refresh_req), .cks_q(cks_q),
  .ie_q(ie_q), .flag_q(flag_q), .cnt_q(cnt_q)
);

// File: tb/sdram_refresh_timer_tb.sv
module sdram_refresh_timer_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, mrst_n = 1'b1, sel = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        refresh_req, irq;

  int tests = 0, fails = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  sdram_refresh_timer dut_i (
    .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .refresh_req(refresh_req), .irq(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (sel && !wr && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s read addr=%0d actual=%h expected=%h", t, addr, rdata, e);
      end
    end
  end

  task automatic chk(input logic ok, input string t, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", t, act, expv);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(posedge clk); #1;
    sel = 1'b0;
  endtask

  task automatic wrr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic wait_req(output int t);
    @(negedge clk);
    while (!refresh_req) @(negedge clk);
    t = cyc;
  endtask

  task automatic interval(input int code, input int div);
    int t0, t1, t2;
    wrr(2'd1, 32'hA55A_0000);
    wrr(2'd0, 32'hA55A_0000 | (code << 3));
    wait_req(t0);
    wait_req(t1);
    @(negedge clk);
    if (code == 1) chk(refresh_req == 1'b0, "R3 request width", refresh_req, 0);
    wait_req(t2);
    chk((t2 - t1) == 2 * div, $sformatf("R3/R7 interval code %0d", code), t2 - t1, 2 * div);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1'b1;
    // R2 / R4 reset state
    rd(2'd0, 32'h0, "R2 csr after por");
    rd(2'd1, 32'h0, "R2 counter after por");
    rd(2'd2, 32'hFF, "R2 constant after por");
    rd(2'd3, 32'h0, "R4 unused address");
    chk(refresh_req == 1'b0 && irq == 1'b0, "R2 outputs idle", refresh_req, 0);
    // R1 keyless writes
    wrr(2'd0, 32'h1234_0048);
    wrr(2'd2, 32'h0000_0011);
    rd(2'd0, 32'h0, "R1 keyless csr");
    rd(2'd2, 32'hFF, "R1 keyless constant");
    // keyed config; R4 upper bits, R6 write-1 to flag
    wrr(2'd2, 32'hA55A_0005);
    wrr(2'd0, 32'hA55A_FFCF);
    rd(2'd0, 32'h48, "R4/R6 csr readback");
    rd(2'd2, 32'h05, "R1 keyed constant");
    // R8 / R5 flag handshake
    @(negedge clk);
    while (!irq) @(negedge clk);
    chk(irq == 1'b1, "R8 irq with enable", irq, 1);
    wrr(2'd0, 32'hA55A_0048);
    rd(2'd0, 32'hC8, "R5 clear without read keeps flag");
    wrr(2'd0, 32'hA55A_0040);
    rd(2'd0, 32'h40, "R5 read then write zero clears");
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq after clear", irq, 0);
    // R7 stopped counter
    wrr(2'd1, 32'hA55A_0033);
    repeat (50) @(posedge clk);
    rd(2'd1, 32'h33, "R7 code 0 holds counter");
    // R9 manual reset
    @(posedge clk); #1 mrst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 mrst_n = 1'b1;
    rd(2'd0, 32'h40, "R2 csr kept by manual reset");
    rd(2'd1, 32'h0, "R9 counter cleared by manual reset");
    rd(2'd2, 32'h05, "R9 constant kept");
    // R3 / R7 intervals
    wrr(2'd2, 32'hA55A_0001);
    interval(1, 4);
    interval(2, 16);
    interval(3, 64);
    interval(4, 256);
    interval(5, 1024);
    interval(6, 2048);
    interval(7, 4096);
    // R2 power-on reset clears csr
    @(posedge clk); #1 por_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 por_n = 1'b1;
    rd(2'd0, 32'h0, "R2 csr after second por");
    rd(2'd2, 32'hFF, "R2 constant after second por");
    repeat (3) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule